// File: doc/BRIEF.md
# Interleaved Three-Channel Timer Register Bank

This block is the software-visible register file of a three-channel timer. A simple 32-bit bus issues word reads and writes. The registers of the three channels are interleaved across one address map. Each word index picks a register group and a channel: the group is the index divided by the channel count, and the channel is the remainder. Consecutive words therefore rotate through channels 0, 1 and 2 within a group.

For every channel the bank holds the following registers:
- clock control
- counter control
- an interval limit
- three match values
- an interrupt enable
- an event control
- a sticky interrupt status

The counter cores live outside the block. They receive the stored fields on output ports. They return their counter value and event count for reads. They send single-cycle source pulses, which the bank latches into the status register. Reading the status returns it and clears it. Each channel raises its interrupt line while any enabled status bit is set.

Top module: `tri_timer_regs`

## Requirements
- R1: The byte offset is taken as word index = offset/4 (offset bits [1:0] ignored). The channel is the word index mod 3, and the group is the word index div 3. The groups, by start offset, are: 0x00 clock control, 0x0C counter control, 0x18 counter value, 0x24 interval, 0x30 match 1, 0x3C match 2, 0x48 match 3, 0x54 interrupt status, 0x60 interrupt enable, 0x6C event control and 0x78 event count.
- R2: Writes keep only the low bits of each register: 6 bits for clock control, 16 bits for interval and match, 6 bits for interrupt enable and 3 bits for event control. Reads return those bits zero-extended to 32 bits.
- R3: Counter control stores write bits [5:0] with bit 4 forced to 0. A write with bit 4 set drives that channel's restart_o high for exactly the one cycle after the accepting edge.
- R4: After reset, every counter control reads 0x21, every other stored register reads 0, irq_o is 0 and restart_o is 0.
- R5: The counter-value and event-count groups read the channel's cnt_val_i and evt_cnt_i inputs, zero-extended. Writes to these groups change nothing.
- R6: A source pulse on bit b of a channel sets status bit b at the next edge. The bit stays set until a status read.
- R7: A status read returns the status held before the edge and clears it. A source pulse in the same cycle as the read stays set after the clear.
- R8: Writes to the interrupt status group leave the status unchanged.
- R9: irq_o[c] is high exactly when (status & enable) of channel c is nonzero.
- R10: Read data and rvalid_o appear in the cycle after a read request. Reads at a word index of 33 or above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| cnt_val_i | input | NUM_CH*16 | Counter value per channel |
| evt_cnt_i | input | NUM_CH*16 | Event count per channel |
| src_pulse_i | input | NUM_CH*6 | Interrupt source pulses, 6 per channel |
| clk_ctrl_o | output | NUM_CH*6 | Clock control fields |
| cnt_ctrl_o | output | NUM_CH*6 | Counter control fields |
| interval_o | output | NUM_CH*16 | Interval limits |
| match_o | output | NUM_CH*48 | Three match values per channel |
| evt_ctrl_o | output | NUM_CH*3 | Event control fields |
| restart_o | output | NUM_CH | Counter restart pulse |
| irq_o | output | NUM_CH | Interrupt line per channel |

## Verification
A status read and a source pulse to the same channel can fall in the same cycle. In that case the clear and the new set compete for the same flops. The bench first sets one status bit with a pulse. It then issues the status read while a different bit pulses in the same cycle. It judges the result in three ways: the returned word must hold only the old bit, the interrupt line must stay high because the new bit is enabled, and a second read must return only the new bit.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int DATA_W    = 32;
  localparam int CLK_W     = 6;
  localparam int CNT_W     = 6;
  localparam int VAL_W     = 16;
  localparam int IEN_W     = 6;
  localparam int EVC_W     = 3;
  localparam int STAT_W    = 6;
  localparam int NUM_MATCH = 3;
  localparam int NUM_GRP   = 11;
  localparam int RST_BIT   = 4;
  localparam logic [CNT_W-1:0] CNT_RST_VAL = 6'h21;

  typedef enum logic [3:0] {
    GRP_CLK  = 4'd0,
    GRP_CNT  = 4'd1,
    GRP_VAL  = 4'd2,
    GRP_INTV = 4'd3,
    GRP_M1   = 4'd4,
    GRP_M2   = 4'd5,
    GRP_M3   = 4'd6,
    GRP_STAT = 4'd7,
    GRP_IEN  = 4'd8,
    GRP_EVC  = 4'd9,
    GRP_EVN  = 4'd10
  } grp_e;
endpackage

// File: rtl/tri_timer_decode.sv
module tri_timer_decode
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output grp_e              grp_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              hit_o
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] grp_idx;
  logic [WORD_W-1:0] ch_idx;
  logic              unused_lsb;

  assign unused_lsb = ^addr_i[1:0];
  assign word       = addr_i[ADDR_W-1:2];
  assign grp_idx    = word / WORD_W'(NUM_CH);
  assign ch_idx     = word % WORD_W'(NUM_CH);
  assign hit_o      = grp_idx < WORD_W'(NUM_GRP);
  assign grp_o      = hit_o ? grp_e'(grp_idx[3:0]) : GRP_CLK;
  assign ch_o       = ch_idx[CH_W-1:0];
endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  grp_e                       grp_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [STAT_W-1:0]          pulse_i,
  input  logic [VAL_W-1:0]           cnt_val_i,
  input  logic [VAL_W-1:0]           evt_cnt_i,
  output logic [CLK_W-1:0]           clk_ctrl_o,
  output logic [CNT_W-1:0]           cnt_ctrl_o,
  output logic [VAL_W-1:0]           interval_o,
  output logic [NUM_MATCH*VAL_W-1:0] match_o,
  output logic [EVC_W-1:0]           evt_ctrl_o,
  output logic                       restart_o,
  output logic                       irq_o,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [CLK_W-1:0]  clk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [VAL_W-1:0]  intv_q;
  logic [VAL_W-1:0]  match_q [NUM_MATCH];
  logic [IEN_W-1:0]  ien_q;
  logic [EVC_W-1:0]  evc_q;
  logic [STAT_W-1:0] stat_q;
  logic              restart_q;
  logic              rd_clr;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:VAL_W];
  assign rd_clr       = rd_en_i && (grp_i == GRP_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q     <= '0;
      cnt_q     <= CNT_RST_VAL;
      intv_q    <= '0;
      ien_q     <= '0;
      evc_q     <= '0;
      restart_q <= 1'b0;
      for (int k = 0; k < NUM_MATCH; k++) match_q[k] <= '0;
    end else begin
      restart_q <= wr_en_i && (grp_i == GRP_CNT) && wdata_i[RST_BIT];
      if (wr_en_i) begin
        unique case (grp_i)
          GRP_CLK:  clk_q  <= wdata_i[CLK_W-1:0];
          GRP_CNT: begin
            cnt_q          <= wdata_i[CNT_W-1:0];
            cnt_q[RST_BIT] <= 1'b0;
          end
          GRP_INTV: intv_q <= wdata_i[VAL_W-1:0];
          GRP_IEN:  ien_q  <= wdata_i[IEN_W-1:0];
          GRP_EVC:  evc_q  <= wdata_i[EVC_W-1:0];
          default: ;
        endcase
        for (int k = 0; k < NUM_MATCH; k++) begin
          if (int'(grp_i) == int'(GRP_M1) + k) match_q[k] <= wdata_i[VAL_W-1:0];
        end
      end
    end
  end

  // clear on read, new pulses win over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (rd_clr ? '0 : stat_q) | pulse_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (grp_i)
      GRP_CLK:  rdata_o = DATA_W'(clk_q);
      GRP_CNT:  rdata_o = DATA_W'(cnt_q);
      GRP_VAL:  rdata_o = DATA_W'(cnt_val_i);
      GRP_INTV: rdata_o = DATA_W'(intv_q);
      GRP_M1:   rdata_o = DATA_W'(match_q[0]);
      GRP_M2:   rdata_o = DATA_W'(match_q[1]);
      GRP_M3:   rdata_o = DATA_W'(match_q[2]);
      GRP_STAT: rdata_o = DATA_W'(stat_q);
      GRP_IEN:  rdata_o = DATA_W'(ien_q);
      GRP_EVC:  rdata_o = DATA_W'(evc_q);
      GRP_EVN:  rdata_o = DATA_W'(evt_cnt_i);
      default:  rdata_o = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
    assign match_o[k*VAL_W +: VAL_W] = match_q[k];
  end

  assign clk_ctrl_o = clk_q;
  assign cnt_ctrl_o = cnt_q;
  assign interval_o = intv_q;
  assign evt_ctrl_o = evc_q;
  assign restart_o  = restart_q;
  assign irq_o      = |(stat_q & ien_q);

  assert_pulse_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i != '0) |=> ((stat_q & $past(pulse_i)) == $past(pulse_i)));
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && pulse_i == '0) |=> (stat_q == '0));
  assert_stat_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && grp_i == GRP_STAT && !rd_clr && pulse_i == '0) |=> $stable(stat_q));
  assert_restart_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && grp_i == GRP_CNT && wdata_i[RST_BIT]) |=> (restart_o && !cnt_ctrl_o[RST_BIT]));
  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [31:0]                       wdata_i,
  output logic [31:0]                       rdata_o,
  output logic                              rvalid_o,
  input  logic [NUM_CH*16-1:0]              cnt_val_i,
  input  logic [NUM_CH*16-1:0]              evt_cnt_i,
  input  logic [NUM_CH*6-1:0]               src_pulse_i,
  output logic [NUM_CH*6-1:0]               clk_ctrl_o,
  output logic [NUM_CH*6-1:0]               cnt_ctrl_o,
  output logic [NUM_CH*16-1:0]              interval_o,
  output logic [NUM_CH*48-1:0]              match_o,
  output logic [NUM_CH*3-1:0]               evt_ctrl_o,
  output logic [NUM_CH-1:0]                 restart_o,
  output logic [NUM_CH-1:0]                 irq_o
);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_W = ADDR_W - 2;
  localparam int MW     = NUM_MATCH * VAL_W;

  grp_e              grp;
  logic [CH_W-1:0]   ch;
  logic              hit;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  tri_timer_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i (addr_i),
    .grp_o  (grp),
    .ch_o   (ch),
    .hit_o  (hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = req_i && hit && (ch == CH_W'(c));
    tri_timer_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (sel && we_i),
      .rd_en_i    (sel && !we_i),
      .grp_i      (grp),
      .wdata_i    (wdata_i),
      .pulse_i    (src_pulse_i[c*STAT_W +: STAT_W]),
      .cnt_val_i  (cnt_val_i[c*VAL_W +: VAL_W]),
      .evt_cnt_i  (evt_cnt_i[c*VAL_W +: VAL_W]),
      .clk_ctrl_o (clk_ctrl_o[c*CLK_W +: CLK_W]),
      .cnt_ctrl_o (cnt_ctrl_o[c*CNT_W +: CNT_W]),
      .interval_o (interval_o[c*VAL_W +: VAL_W]),
      .match_o    (match_o[c*MW +: MW]),
      .evt_ctrl_o (evt_ctrl_o[c*EVC_W +: EVC_W]),
      .restart_o  (restart_o[c]),
      .irq_o      (irq_o[c]),
      .rdata_o    (ch_rdata[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && ch == CH_W'(c)) rd_mux = ch_rdata[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_read_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  assert_undecoded_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:2] >= WORD_W'(NUM_GRP*NUM_CH)) |=> (rdata_o == '0));
  assert_no_read_valid_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> !rvalid_o);
endmodule

// File: tb/tri_timer_regs_test.sv
module tri_timer_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [47:0] cnt_val = {16'h3333, 16'h2222, 16'h1111};
  logic [47:0] evt_cnt = {16'h0C0C, 16'h0B0B, 16'h0A0A};
  logic [17:0] src_pulse = '0;
  logic [17:0] clk_ctrl, cnt_ctrl;
  logic [47:0] interval;
  logic [143:0] match;
  logic [8:0]  evt_ctrl;
  logic [2:0]  restart, irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_timer_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .cnt_val_i(cnt_val), .evt_cnt_i(evt_cnt), .src_pulse_i(src_pulse),
    .clk_ctrl_o(clk_ctrl), .cnt_ctrl_o(cnt_ctrl), .interval_o(interval),
    .match_o(match), .evt_ctrl_o(evt_ctrl), .restart_o(restart), .irq_o(irq)
  );

  // {we, addr, data, expected}
  localparam int NV = 26;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h0000_003F},
    {1'b0, 8'h04, 32'h0, 32'h0},
    {1'b1, 8'h28, 32'h1234_5678, 32'h0},
    {1'b0, 8'h28, 32'h0, 32'h0000_5678},
    {1'b0, 8'h24, 32'h0, 32'h0},
    {1'b0, 8'h2C, 32'h0, 32'h0},
    {1'b1, 8'h50, 32'hABCD_EF01, 32'h0},
    {1'b0, 8'h50, 32'h0, 32'h0000_EF01},
    {1'b0, 8'h48, 32'h0, 32'h0},
    {1'b1, 8'h70, 32'h0000_00FF, 32'h0},
    {1'b0, 8'h70, 32'h0, 32'h0000_0007},
    {1'b1, 8'h68, 32'h0000_00FF, 32'h0},
    {1'b0, 8'h68, 32'h0, 32'h0000_003F},
    {1'b0, 8'h10, 32'h0, 32'h0000_0021},
    {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h14, 32'h0, 32'h0000_002F},
    {1'b1, 8'h18, 32'h0000_FFFF, 32'h0},
    {1'b0, 8'h18, 32'h0, 32'h0000_1111},
    {1'b0, 8'h20, 32'h0, 32'h0000_3333},
    {1'b0, 8'h7C, 32'h0, 32'h0000_0B0B},
    {1'b0, 8'h84, 32'h0, 32'h0},
    {1'b0, 8'hFC, 32'h0, 32'h0},
    {1'b1, 8'h3C, 32'h0000_BEEF, 32'h0},
    {1'b0, 8'h3C, 32'h0, 32'h0000_BEEF},
    {1'b0, 8'h40, 32'h0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    chk("R10 rvalid", 32'(rvalid), 32'h1);
    d = rdata;
  endtask

  task automatic pulse(input int ch, input int b);
    @(negedge clk); src_pulse = '0; src_pulse[ch*6+b] = 1'b1;
    @(negedge clk); src_pulse = '0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 cnt_ctrl", 32'(cnt_ctrl), 32'(18'h21861));
    chk("R4 irq", 32'(irq), 32'h0);
    chk("R4 restart", 32'(restart), 32'h0);
    chk("R4 clk_ctrl", 32'(clk_ctrl), 32'h0);
    chk("R4 rvalid", 32'(rvalid), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], d);
        chk($sformatf("[R1,R2,R3,R4,R5,R10] vec %0d", i), d, VEC[i][31:0]);
      end
    end
    chk("R2 interval port ch1", 32'(interval[31:16]), 32'h5678);
    chk("R2 match3 port ch2", 32'(match[96+32 +: 16]), 32'hEF01);
    chk("R2 evt_ctrl port ch1", 32'(evt_ctrl[5:3]), 32'h7);

    // R3 restart pulse
    @(negedge clk); req = 1; we = 1; addr = 8'h0C; wdata = 32'h11;
    @(negedge clk); req = 0; we = 0;
    chk("R3 restart high", 32'(restart), 32'h1);
    @(negedge clk);
    chk("R3 restart one cycle", 32'(restart), 32'h0);
    rd(8'h0C, d);
    chk("R3 bit4 dropped", d, 32'h1);

    // R9 masking, R6 sticky, R7 clear
    pulse(1, 2);
    chk("R9 masked ch1", 32'(irq[1]), 32'h0);
    wr(8'h64, 32'h04);
    chk("R9 irq ch1 after enable", 32'(irq), 32'b010);
    rd(8'h58, d);
    chk("R7 status read", d, 32'h04);
    chk("R7 irq dropped", 32'(irq), 32'h0);
    rd(8'h58, d);
    chk("R7 status cleared", d, 32'h0);

    // R7 read and pulse in same cycle
    pulse(1, 0);
    @(negedge clk); req = 1; we = 0; addr = 8'h58; src_pulse = 18'h0; src_pulse[6+2] = 1'b1;
    @(negedge clk); req = 0; src_pulse = '0;
    chk("R7 old value returned", rdata, 32'h01);
    chk("R7 new pulse keeps irq", 32'(irq[1]), 32'h1);
    rd(8'h58, d);
    chk("R7 new pulse survives clear", d, 32'h04);

    // R8 status write ignored
    pulse(2, 5);
    chk("R9 irq ch2", 32'(irq), 32'b100);
    wr(8'h5C, 32'hFFFF_FFFF);
    chk("R8 irq unchanged", 32'(irq), 32'b100);
    rd(8'h5C, d);
    chk("R8 status unchanged", d, 32'h20);

    // R6 sticky over idle cycles
    pulse(0, 1);
    repeat (5) @(negedge clk);
    rd(8'h54, d);
    chk("R6 sticky bit", d, 32'h02);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule